// File: doc/BRIEF.md
# Full-Frame CCD Readout Clock Sequencer

This block produces the digital phase clocks that read out a two-phase full-frame CCD. A start request opens an integration window. Both vertical phases stay low for that window. The readout then runs on its own, line by line. For each line the block pulses vertical phase 1 and then vertical phase 2 to move one row into the horizontal register. The row lands when phase 2 falls. Horizontal phase 1 stays high for the whole transfer. After a setup gap the two horizontal phases run as complementary clocks for one pixel period per column.

The output-node reset clock fires at the start of every pixel period, and it keeps firing while the sensor is idle or integrating. Each pixel period ends with a one-cycle sample strobe for the downstream sampler. The strobe carries the column number, the row number and a region code. Every duration is a configuration input counted in system-clock cycles. The frame geometry is set by parameters, and the defaults give 520 rows of 796 pixel periods. All configuration inputs must be held stable while a frame is running.

Top module: `ccd_frame_seq`

## Requirements
- R1: An accepted start gives `cfg_int` cycles of integration with both vertical phases low. ROWS lines follow (520 by default). `frame_done` is high for exactly one cycle, the cycle after the last pixel period of the last row. The whole frame therefore spans cfg_int + ROWS*(2*cfg_vpulse + cfg_setup + PIXELS*cfg_pix) cycles. A duration input of 0 counts as 1.
- R2: Each line starts with `v_ph1` high for `cfg_vpulse` cycles. `v_ph2` then goes high in the very next cycle and stays high for `cfg_vpulse` cycles. The two vertical phases are never high together.
- R3: `h_ph1` is high and `h_ph2` is low whenever a vertical phase is high. Exactly `cfg_setup` cycles pass between the fall of `v_ph2` and the rise of `h_ph2`.
- R4: A line has PIXELS pixel periods (796 by default), each `cfg_pix` cycles long. In each period `h_ph2` is high for the first floor(cfg_pix/2) cycles and `h_ph1` is its complement. `h_ph1` and `h_ph2` never have equal values.
- R5: `node_rst` is high for the first `cfg_rst_w` cycles of every pixel period. It also runs freely with period `cfg_pix` outside readout.
- R6: `smp_stb` is high in the last cycle of each pixel period, never together with `node_rst`. It is followed by a `node_rst` cycle when `cfg_rst_w` is nonzero. The strobe carries `smp_col` (1..796, in order) and `smp_row` (1..520, in order).
- R7: `smp_region` uses these codes: 0 = dummy, 1 = dark, 2 = active. With default parameters, columns 1–10 and 795–796 are dummy in every row. Columns 11–14 and 783–794 are dark. Rows 1–4 and 517–520 are dark in every non-dummy column. All remaining positions are active.
- R8: A start is ignored when `cfg_pix` < `cfg_rst_w` + 1, and it is also ignored while a frame is in progress.
- R9: `abort` puts the block into idle by the next cycle: both vertical phases low, `h_ph1` high, `h_ph2` low, no strobe. The aborted frame never raises `frame_done`.
- R10: While reset is asserted and just after it is released, the outputs sit at idle levels, with no strobe and no `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new frame |
| abort | input | 1 | Stop the frame and return the clocks to idle |
| cfg_pix | input | TW | Pixel period in cycles |
| cfg_rst_w | input | TW | Reset clock pulse width in cycles |
| cfg_vpulse | input | TW | Width of each vertical phase pulse in cycles |
| cfg_setup | input | TW | Gap from the row transfer to horizontal clocking, in cycles |
| cfg_int | input | IW | Integration length in cycles |
| v_ph1 | output | 1 | Vertical phase 1 |
| v_ph2 | output | 1 | Vertical phase 2 |
| h_ph1 | output | 1 | Horizontal phase 1 |
| h_ph2 | output | 1 | Horizontal phase 2 |
| node_rst | output | 1 | Output node reset clock |
| smp_stb | output | 1 | Sample strobe |
| smp_col | output | CWID | Column of the current pixel period |
| smp_row | output | RWID | Row of the current line |
| smp_region | output | 2 | Region code of the current pixel period |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench drives frames with a shrunken geometry. The configurations include one whose pixel period is exactly one cycle longer than the reset width. A design with a wrong rejection bound would refuse that frame or accept the illegal one. Each strobe is checked against an independently kept column, row and region. Off-by-one errors at the dummy/dark and dark-row edges, or a line that is one period short or long, show up as a wrong tag, a wrong strobe count or a shifted `frame_done` cycle. Further tests raise start in the middle of a frame, abort during the second row, and watch `node_rst` while idle. These catch a restarted frame, clocks left mid-phase after an abort, and a reset clock that stops outside readout.

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq #(
  parameter int DUMMY_HEAD  = 10,
  parameter int DARK_HEAD   = 4,
  parameter int ACTIVE_COLS = 768,
  parameter int DARK_TAIL   = 12,
  parameter int DUMMY_TAIL  = 2,
  parameter int DARK_TOP    = 4,
  parameter int ACTIVE_ROWS = 512,
  parameter int DARK_BOT    = 4,
  parameter int TW          = 16,
  parameter int IW          = 24,
  localparam int PIXELS = DUMMY_HEAD + DARK_HEAD + ACTIVE_COLS + DARK_TAIL + DUMMY_TAIL,
  localparam int ROWS   = DARK_TOP + ACTIVE_ROWS + DARK_BOT,
  localparam int CWID   = $clog2(PIXELS + 1),
  localparam int RWID   = $clog2(ROWS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic [TW-1:0]   cfg_pix,
  input  logic [TW-1:0]   cfg_rst_w,
  input  logic [TW-1:0]   cfg_vpulse,
  input  logic [TW-1:0]   cfg_setup,
  input  logic [IW-1:0]   cfg_int,
  output logic            v_ph1,
  output logic            v_ph2,
  output logic            h_ph1,
  output logic            h_ph2,
  output logic            node_rst,
  output logic            smp_stb,
  output logic [CWID-1:0] smp_col,
  output logic [RWID-1:0] smp_row,
  output logic [1:0]      smp_region,
  output logic            frame_done
);

  localparam logic [CWID-1:0] COL_DK0  = CWID'(DUMMY_HEAD);
  localparam logic [CWID-1:0] COL_ACT0 = CWID'(DUMMY_HEAD + DARK_HEAD);
  localparam logic [CWID-1:0] COL_ACT1 = CWID'(DUMMY_HEAD + DARK_HEAD + ACTIVE_COLS);
  localparam logic [CWID-1:0] COL_DK1  = CWID'(PIXELS - DUMMY_TAIL);
  localparam logic [CWID-1:0] COL_LAST = CWID'(PIXELS);
  localparam logic [RWID-1:0] ROW_ACT0 = RWID'(DARK_TOP);
  localparam logic [RWID-1:0] ROW_ACT1 = RWID'(DARK_TOP + ACTIVE_ROWS);
  localparam logic [RWID-1:0] ROW_LAST = RWID'(ROWS);

  typedef enum logic [2:0] {S_IDLE, S_INT, S_VA, S_VB, S_SET, S_HOR} state_t;

  state_t          st;
  logic [IW-1:0]   tcnt;
  logic [TW-1:0]   pcnt;
  logic [CWID-1:0] col;
  logic [RWID-1:0] row;
  logic            done_q;
  logic [IW:0]     dur;

  always_comb begin
    case (st)
      S_INT:       dur = {1'b0, cfg_int};
      S_VA, S_VB:  dur = (IW+1)'(cfg_vpulse);
      S_SET:       dur = (IW+1)'(cfg_setup);
      default:     dur = '0;
    endcase
  end

  wire t_end    = ({1'b0, tcnt} + (IW+1)'(1)) >= dur;
  wire pix_end  = ({1'b0, pcnt} + (TW+1)'(1)) >= {1'b0, cfg_pix};
  wire start_ok = start && (cfg_pix > cfg_rst_w);
  wire in_hor   = (st == S_HOR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tcnt   <= '0;
      pcnt   <= '0;
      col    <= CWID'(1);
      row    <= RWID'(1);
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pcnt   <= pix_end ? '0 : pcnt + TW'(1);
      tcnt   <= tcnt + IW'(1);
      if (abort) begin
        st   <= S_IDLE;
        tcnt <= '0;
      end else begin
        case (st)
          S_IDLE: if (start_ok) begin st <= S_INT; tcnt <= '0; row <= RWID'(1); end
          S_INT:  if (t_end) begin st <= S_VA;  tcnt <= '0; end
          S_VA:   if (t_end) begin st <= S_VB;  tcnt <= '0; end
          S_VB:   if (t_end) begin st <= S_SET; tcnt <= '0; end
          S_SET:  if (t_end) begin
                    st   <= S_HOR;
                    pcnt <= '0;
                    col  <= CWID'(1);
                  end
          S_HOR:  if (pix_end) begin
                    if (col == COL_LAST) begin
                      if (row == ROW_LAST) begin
                        st     <= S_IDLE;
                        done_q <= 1'b1;
                      end else begin
                        row  <= row + RWID'(1);
                        st   <= S_VA;
                        tcnt <= '0;
                      end
                    end else begin
                      col <= col + CWID'(1);
                    end
                  end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  wire col_dummy = (col <= COL_DK0) || (col > COL_DK1);
  wire col_dark  = (col <= COL_ACT0) || (col > COL_ACT1);
  wire row_dark  = (row <= ROW_ACT0) || (row > ROW_ACT1);

  assign v_ph1      = (st == S_VA);
  assign v_ph2      = (st == S_VB);
  assign h_ph2      = in_hor && (pcnt < (cfg_pix >> 1));
  assign h_ph1      = !h_ph2;
  assign node_rst   = pcnt < cfg_rst_w;
  assign smp_stb    = in_hor && pix_end;
  assign smp_col    = col;
  assign smp_row    = row;
  assign smp_region = col_dummy ? 2'd0 : ((col_dark || row_dark) ? 2'd1 : 2'd2);
  assign frame_done = done_q;

endmodule

// File: rtl/ccd_frame_seq_chk.sv
module ccd_frame_seq_chk #(
  parameter int COLS = 796,
  parameter int ROWS = 520,
  parameter int TW   = 16,
  localparam int CWID = $clog2(COLS + 1),
  localparam int RWID = $clog2(ROWS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            abort,
  input logic [TW-1:0]   cfg_rst_w,
  input logic            v_ph1,
  input logic            v_ph2,
  input logic            h_ph1,
  input logic            h_ph2,
  input logic            node_rst,
  input logic            smp_stb,
  input logic [CWID-1:0] smp_col,
  input logic [RWID-1:0] smp_row,
  input logic            frame_done
);

  // R2
  vexcl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(v_ph1 && v_ph2));

  // R2
  vorder_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(v_ph2) |-> $past(v_ph1));

  // R3
  hhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_ph1 || v_ph2) |-> (h_ph1 && !h_ph2));

  // R4
  hcomp_chk: assert property (@(posedge clk) disable iff (!rst_n) h_ph1 != h_ph2);

  // R6
  stb_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && cfg_rst_w != '0) |=> node_rst);

  // R6
  stb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_stb |-> !node_rst);

  // R6
  stb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (smp_col >= CWID'(1) && smp_col <= CWID'(COLS) &&
                 smp_row >= RWID'(1) && smp_row <= RWID'(ROWS)));

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done);

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!v_ph1 && !v_ph2 && h_ph1 && !h_ph2 && !smp_stb));

endmodule

bind ccd_frame_seq ccd_frame_seq_chk #(.COLS(PIXELS), .ROWS(ROWS), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .abort      (abort),
  .cfg_rst_w  (cfg_rst_w),
  .v_ph1      (v_ph1),
  .v_ph2      (v_ph2),
  .h_ph1      (h_ph1),
  .h_ph2      (h_ph2),
  .node_rst   (node_rst),
  .smp_stb    (smp_stb),
  .smp_col    (smp_col),
  .smp_row    (smp_row),
  .frame_done (frame_done)
);

// File: tb/ccd_frame_seq_tb.sv
`timescale 1ns/1ps
module ccd_frame_seq_tb_top;

  localparam int NCOL = 9;
  localparam int NROW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        abort = 1'b0;
  logic [15:0] cfg_pix = 16'd4, cfg_rst_w = 16'd1, cfg_vpulse = 16'd2, cfg_setup = 16'd1;
  logic [23:0] cfg_int = 24'd2;
  logic        v_ph1, v_ph2, h_ph1, h_ph2, node_rst, smp_stb, frame_done;
  logic [3:0]  smp_col;
  logic [2:0]  smp_row;
  logic [1:0]  smp_region;

  always #2 clk = ~clk;

  ccd_frame_seq #(
    .DUMMY_HEAD(2), .DARK_HEAD(1), .ACTIVE_COLS(3), .DARK_TAIL(2), .DUMMY_TAIL(1),
    .DARK_TOP(1), .ACTIVE_ROWS(2), .DARK_BOT(1), .TW(16), .IW(24)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .cfg_pix(cfg_pix), .cfg_rst_w(cfg_rst_w), .cfg_vpulse(cfg_vpulse),
    .cfg_setup(cfg_setup), .cfg_int(cfg_int),
    .v_ph1(v_ph1), .v_ph2(v_ph2), .h_ph1(h_ph1), .h_ph2(h_ph2),
    .node_rst(node_rst), .smp_stb(smp_stb), .smp_col(smp_col),
    .smp_row(smp_row), .smp_region(smp_region), .frame_done(frame_done)
  );

  // {pix, rst_w, vpulse, setup, int}
  localparam logic [79:0] VEC [3] = '{
    {16'd4, 16'd1, 16'd3, 16'd2, 16'd5},
    {16'd7, 16'd3, 16'd1, 16'd1, 16'd1},
    {16'd2, 16'd1, 16'd5, 16'd4, 16'd20}
  };

  int n_run = 0, n_fail = 0;
  bit mon_en = 1'b0, arm = 1'b0;
  int ecol, erow, nstb, h2cnt, v1run, v2run, gap, last_stb, cyc;
  bit gap_on, stb_prev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_region(input int c, input int r);
    if (c <= 2 || c >= 9) return 0;
    if (r == 1 || r == 4 || c == 3 || c >= 7) return 1;
    return 2;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (arm) begin
      ecol = 1; erow = 1; nstb = 0; h2cnt = 0; v1run = 0; v2run = 0;
      gap_on = 0; stb_prev = 0;
    end else if (mon_en && rst_n) begin
      if (stb_prev) chk(node_rst == 1'b1, "R6 rst after stb", int'(node_rst), 1);
      stb_prev = smp_stb;
      if (gap_on) begin
        if (h_ph2) begin chk(gap == int'(cfg_setup), "R3 setup gap", gap, int'(cfg_setup)); gap_on = 0; end
        else gap++;
      end
      if (v_ph1) v1run++;
      else if (v1run != 0) begin
        chk(v1run == int'(cfg_vpulse), "R2 v1 width", v1run, int'(cfg_vpulse));
        chk(v_ph2 == 1'b1, "R2 v2 follows v1", int'(v_ph2), 1);
        v1run = 0;
      end
      if (v_ph2) v2run++;
      else if (v2run != 0) begin
        chk(v2run == int'(cfg_vpulse), "R2 v2 width", v2run, int'(cfg_vpulse));
        v2run = 0; gap = 1; gap_on = 1;
      end
      if (v_ph1 || v_ph2) chk(h_ph1 && !h_ph2, "R3 h1 hold", int'(h_ph1), 1);
      chk(h_ph1 != h_ph2, "R4 complement", int'(h_ph1), int'(!h_ph2));
      if (h_ph2) h2cnt++;
      if (smp_stb) begin
        chk(int'(smp_col) == ecol, "R6 col", int'(smp_col), ecol);
        chk(int'(smp_row) == erow, "R6 row", int'(smp_row), erow);
        chk(int'(smp_region) == exp_region(ecol, erow), "R7 region",
            int'(smp_region), exp_region(ecol, erow));
        chk(h2cnt == int'(cfg_pix) / 2, "R4 h2 high time", h2cnt, int'(cfg_pix) / 2);
        if (ecol > 1) chk(cyc - last_stb == int'(cfg_pix), "R4 period", cyc - last_stb, int'(cfg_pix));
        last_stb = cyc; h2cnt = 0; nstb++;
        if (ecol == NCOL) begin ecol = 1; erow++; end else ecol++;
      end
    end
  end

  task automatic setup_cfg(input logic [79:0] v);
    @(negedge clk); #1;
    {cfg_pix, cfg_rst_w, cfg_vpulse, cfg_setup} = v[79:16];
    cfg_int = {8'd0, v[15:0]};
    arm = 1'b1;
    @(negedge clk); #1;
    arm = 1'b0;
  endtask

  task automatic run_frame(input logic [79:0] v);
    int k, first_v, lines, expk;
    setup_cfg(v);
    mon_en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    k = 1; first_v = 0;
    lines = 2 * int'(cfg_vpulse) + int'(cfg_setup) + NCOL * int'(cfg_pix);
    expk = int'(cfg_int) + NROW * lines + 1;
    while (!frame_done && k < 5000) begin
      if (v_ph1 && first_v == 0) first_v = k;
      #1 start = (k == int'(cfg_int) + 10);
      @(negedge clk);
      k++;
    end
    chk(k == expk, "R1 frame_done cycle / R8 mid-frame start", k, expk);
    chk(first_v == int'(cfg_int) + 1, "R1 integration length", first_v, int'(cfg_int) + 1);
    chk(nstb == NROW * NCOL, "R1 strobe count", nstb, NROW * NCOL);
    @(negedge clk);
    chk(!frame_done, "R1 done pulse width", int'(frame_done), 0);
  endtask

  initial begin
    int seen_v, seen_d, rgc;
    repeat (3) @(negedge clk);
    // R10
    chk(!v_ph1 && !v_ph2 && h_ph1 && !h_ph2 && !smp_stb && !frame_done, "R10 in reset",
        int'({v_ph1, v_ph2, h_ph1, h_ph2}), 2);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!v_ph1 && !v_ph2 && h_ph1 && !h_ph2 && !smp_stb && !frame_done, "R10 after reset",
        int'({v_ph1, v_ph2, h_ph1, h_ph2}), 2);

    for (int i = 0; i < 3; i++) run_frame(VEC[i]);

    // R5: free-running reset clock while idle, pix 5 width 2
    @(negedge clk); #1 cfg_pix = 16'd5; cfg_rst_w = 16'd2;
    repeat (3) @(negedge clk);
    rgc = 0;
    for (int j = 0; j < 20; j++) begin @(negedge clk); if (node_rst) rgc++; end
    chk(rgc == 8, "R5 idle reset pulses", rgc, 8);

    // R8: start with pix < rst_w + 1 is ignored
    setup_cfg({16'd3, 16'd3, 16'd1, 16'd1, 16'd1});
    start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    seen_v = 0; seen_d = 0;
    for (int j = 0; j < 60; j++) begin @(negedge clk); if (v_ph1 || v_ph2) seen_v++; if (frame_done) seen_d++; end
    chk(seen_v == 0 && seen_d == 0, "R8 rejected start", seen_v + seen_d, 0);

    // R9: abort in row 2
    setup_cfg(VEC[0]);
    start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    for (int j = 0; j < 2000; j++) begin
      @(negedge clk);
      if (smp_stb && smp_row == 3'd2) break;
    end
    mon_en = 1'b0;
    #1 abort = 1'b1;
    @(negedge clk);
    chk(!v_ph1 && !v_ph2 && h_ph1 && !h_ph2 && !smp_stb, "R9 idle after abort",
        int'({v_ph1, v_ph2, h_ph1, h_ph2, smp_stb}), 4);
    #1 abort = 1'b0;
    seen_v = 0; seen_d = 0;
    for (int j = 0; j < 300; j++) begin @(negedge clk); if (v_ph1 || v_ph2 || h_ph2) seen_v++; if (frame_done) seen_d++; end
    chk(seen_v == 0, "R9 clocks stay idle", seen_v, 0);
    chk(seen_d == 0, "R9 no done for aborted frame", seen_d, 0);
    run_frame(VEC[1]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule